// File: doc/BRIEF.md
# Accumulator and Link Logic Unit

This block holds a 16-bit accumulator (AC), a single link bit (E) that acts as carry and rotate extension, and the adder-and-logic path that updates them. A controller upstream decodes instructions and raises one strobe per cycle. Three strobes belong to memory-reference operations (bitwise AND, add, load), and each takes a 16-bit operand from the data register. One strobe belongs to the character-input transfer, which takes an 8-bit character from the input port. The last strobe marks a register-reference instruction, and it comes with a 12-bit field in which each bit requests one operation.

The unit reports whether a register-reference instruction asks to skip the next instruction. The report is a combinational output driven from the accumulator and link values as they stand before the update. The unit also keeps a run flag that the halt bit clears. Fetching, memory access and the program counter all sit outside the block. The controller reads the skip output and decides what to do with it.

Reset is asynchronous and active low, and its release is synchronised inside the block over two clock edges.

Top module: `acc_link_unit`

## Requirements
- R1: After reset, AC reads 0x0000, E reads 0, the run flag reads 1 and skip reads 0. Asserting reset again restores this state at any time.
- R2: The AND strobe sets AC to AC bitwise-AND the operand on the next edge and leaves E unchanged.
- R3: The add strobe sets AC to the low 16 bits of AC plus the operand and sets E to the carry out, both on the next edge.
- R4: The load strobe copies the operand into AC and leaves E unchanged.
- R5: The input strobe replaces AC bits 7..0 with the character and leaves AC bits 15..8 and E unchanged.
- R6: In the register field, bit 11 (0x800) clears AC, bit 10 (0x400) clears E, bit 9 (0x200) inverts every bit of AC, and bit 8 (0x100) inverts E.
- R7: Field bit 7 (0x080) rotates {E,AC} right: E moves into AC bit 15 and AC bit 0 moves into E. Field bit 6 (0x040) rotates left: E moves into AC bit 0 and AC bit 15 moves into E.
- R8: Field bit 5 (0x020) adds one to AC, wraps 0xFFFF to 0x0000 and leaves E unchanged.
- R9: When several of field bits 11..5 are set together, they take effect within one cycle in the order bit 11 first and bit 5 last. Each operation acts on the result of the one before it.
- R10: While the register strobe is high, skip is the OR of four tests: bit 4 (0x010) with AC bit 15 equal to 0, bit 3 (0x008) with AC bit 15 equal to 1, bit 2 (0x004) with AC equal to zero, and bit 1 (0x002) with E equal to 0. All four tests use the values before the update. Skip is 0 while the register strobe is low. The skip bits alone leave AC and E unchanged.
- R11: Field bit 0 (0x001) clears the run flag on the next edge. Only reset sets it again.
- R12: At most one strobe is high per cycle. When no strobe is high, AC and E keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_and | input | 1 | Strobe: AC becomes AC AND operand |
| mem_add | input | 1 | Strobe: add operand to AC, carry into E |
| mem_lda | input | 1 | Strobe: load operand into AC |
| io_inp | input | 1 | Strobe: load character into AC low byte |
| rr_valid | input | 1 | Strobe: register-reference field is valid |
| rr_field | input | 12 | One bit per register-reference operation |
| dr_in | input | 16 | Operand from the data register |
| char_in | input | 8 | Character from the input port |
| acc_out | output | 16 | Accumulator value |
| link_out | output | 1 | Link bit value |
| run_out | output | 1 | Run flag |
| skip_out | output | 1 | Skip request for the current register instruction |

## Verification
AC and E drive the ports directly, so a wrong accumulator or link state shows at the edge right after the strobe that caused it. A wrong skip decision appears in the same cycle as the instruction, because skip is driven from the state before the update. A wrong operation order only shows for certain combinations of field bits, so the bench runs every combination of bits 11..5 from pseudo-random start states. A run flag that fails to stay cleared shows on the next operation that follows a halt.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;
  // register-reference field: one bit per operation, bit order is the apply order
  localparam int RR_W  = 12;
  localparam int B_CLA = 11;
  localparam int B_CLE = 10;
  localparam int B_CMA = 9;
  localparam int B_CME = 8;
  localparam int B_CIR = 7;
  localparam int B_CIL = 6;
  localparam int B_INC = 5;
  localparam int B_SPA = 4;
  localparam int B_SNA = 3;
  localparam int B_SZA = 2;
  localparam int B_SZE = 1;
  localparam int B_HLT = 0;
  // widths of the slices handed to the sub-units
  localparam int CHAIN_W = B_CLA - B_INC + 1;
  localparam int SKIP_W  = B_SPA - B_SZE + 1;
endpackage

// File: rtl/acc_rr_chain.sv
module acc_rr_chain
  import acc_link_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [CHAIN_W-1:0] ops,
  input  logic [W-1:0]       acc_i,
  input  logic               link_i,
  output logic [W-1:0]       acc_o,
  output logic               link_o
);
  localparam int O_CLA = B_CLA - B_INC;
  localparam int O_CLE = B_CLE - B_INC;
  localparam int O_CMA = B_CMA - B_INC;
  localparam int O_CME = B_CME - B_INC;
  localparam int O_CIR = B_CIR - B_INC;
  localparam int O_CIL = B_CIL - B_INC;
  localparam int O_INC = 0;

  logic [W-1:0] a;
  logic         l;
  logic         t;

  // operations apply in field order, each on the previous result
  always_comb begin
    a = acc_i;
    l = link_i;
    t = 1'b0;
    if (ops[O_CLA]) a = '0;
    if (ops[O_CLE]) l = 1'b0;
    if (ops[O_CMA]) a = ~a;
    if (ops[O_CME]) l = ~l;
    if (ops[O_CIR]) begin
      t = a[0];
      a = {l, a[W-1:1]};
      l = t;
    end
    if (ops[O_CIL]) begin
      t = a[W-1];
      a = {a[W-2:0], l};
      l = t;
    end
    if (ops[O_INC]) a = a + 1'b1;
    acc_o  = a;
    link_o = l;
  end
endmodule

// File: rtl/acc_mem_alu.sv
module acc_mem_alu #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          op_and,
  input  logic          op_add,
  input  logic          op_lda,
  input  logic          op_inp,
  input  logic [W-1:0]  acc_i,
  input  logic          link_i,
  input  logic [W-1:0]  dr_i,
  input  logic [CW-1:0] chr_i,
  output logic [W-1:0]  acc_o,
  output logic          link_o
);
  logic [W:0] sum;

  assign sum = {1'b0, acc_i} + {1'b0, dr_i};

  always_comb begin
    acc_o  = acc_i;
    link_o = link_i;
    if (op_and) begin
      acc_o = acc_i & dr_i;
    end else if (op_add) begin
      acc_o  = sum[W-1:0];
      link_o = sum[W];
    end else if (op_lda) begin
      acc_o = dr_i;
    end else if (op_inp) begin
      acc_o = {acc_i[W-1:CW], chr_i};
    end
  end
endmodule

// File: rtl/acc_skip_eval.sv
module acc_skip_eval
  import acc_link_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              valid,
  input  logic [SKIP_W-1:0] sel,
  input  logic [W-1:0]      acc_i,
  input  logic              link_i,
  output logic              skip
);
  localparam int O_SPA = B_SPA - B_SZE;
  localparam int O_SNA = B_SNA - B_SZE;
  localparam int O_SZA = B_SZA - B_SZE;
  localparam int O_SZE = 0;

  logic [SKIP_W-1:0] hit;

  always_comb begin
    hit        = '0;
    hit[O_SPA] = sel[O_SPA] & ~acc_i[W-1];
    hit[O_SNA] = sel[O_SNA] &  acc_i[W-1];
    hit[O_SZA] = sel[O_SZA] & (acc_i == '0);
    hit[O_SZE] = sel[O_SZE] & ~link_i;
    skip       = valid & (|hit);
  end
endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
  import acc_link_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_and,
  input  logic            mem_add,
  input  logic            mem_lda,
  input  logic            io_inp,
  input  logic            rr_valid,
  input  logic [RR_W-1:0] rr_field,
  input  logic [W-1:0]    dr_in,
  input  logic [CW-1:0]   char_in,
  output logic [W-1:0]    acc_out,
  output logic            link_out,
  output logic            run_out,
  output logic            skip_out
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  logic [W-1:0] acc_q, acc_d, acc_rr, acc_mem;
  logic         link_q, link_d, link_rr, link_mem;
  logic         run_q, run_d;
  logic         acc_en, run_en;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  acc_rr_chain #(.W(W)) u_chain (
    .ops    (rr_field[B_CLA:B_INC]),
    .acc_i  (acc_q),
    .link_i (link_q),
    .acc_o  (acc_rr),
    .link_o (link_rr)
  );

  acc_mem_alu #(.W(W), .CW(CW)) u_alu (
    .op_and (mem_and),
    .op_add (mem_add),
    .op_lda (mem_lda),
    .op_inp (io_inp),
    .acc_i  (acc_q),
    .link_i (link_q),
    .dr_i   (dr_in),
    .chr_i  (char_in),
    .acc_o  (acc_mem),
    .link_o (link_mem)
  );

  acc_skip_eval #(.W(W)) u_skip (
    .valid  (rr_valid),
    .sel    (rr_field[B_SPA:B_SZE]),
    .acc_i  (acc_q),
    .link_i (link_q),
    .skip   (skip_out)
  );

  // next state and clock enables
  always_comb begin
    acc_en = rr_valid | mem_and | mem_add | mem_lda | io_inp;
    run_en = rr_valid & rr_field[B_HLT];
    run_d  = 1'b0;
    if (rr_valid) begin
      acc_d  = acc_rr;
      link_d = link_rr;
    end else begin
      acc_d  = acc_mem;
      link_d = link_mem;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q  <= '0;
      link_q <= 1'b0;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      link_q <= link_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  run_q <= 1'b1;
    else if (run_en)  run_q <= run_d;
  end

  assign acc_out  = acc_q;
  assign link_out = link_q;
  assign run_out  = run_q;
endmodule

// File: rtl/acc_link_checker.sv
module acc_link_checker #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          mem_and,
  input logic          mem_add,
  input logic          mem_lda,
  input logic          io_inp,
  input logic          rr_valid,
  input logic [11:0]   rr_field,
  input logic [W-1:0]  dr_in,
  input logic [CW-1:0] char_in,
  input logic [W-1:0]  acc_out,
  input logic          link_out,
  input logic          run_out,
  input logic          skip_out
);
  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({mem_and, mem_add, mem_lda, io_inp, rr_valid}));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_and | mem_add | mem_lda | io_inp | rr_valid) |=> $stable(acc_out) && $stable(link_out));

  assert_and_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_and |=> acc_out == $past(acc_out & dr_in) && $stable(link_out));

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_add |=> {link_out, acc_out} == $past({1'b0, acc_out} + {1'b0, dr_in}));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_lda |=> acc_out == $past(dr_in) && $stable(link_out));

  assert_input_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    io_inp |=> acc_out[CW-1:0] == $past(char_in) && $stable(acc_out[W-1:CW]) && $stable(link_out));

  assert_inc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rr_valid && rr_field == 12'h020) |=> acc_out == $past(acc_out + 1'b1) && $stable(link_out));

  assert_skip_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rr_valid && rr_field == 12'h004) |-> skip_out == (acc_out == '0));

  assert_skip_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rr_valid |-> !skip_out);

  assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rr_valid && rr_field[0]) |=> !run_out);

  assert_run_sticky_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_out |=> !run_out);
endmodule

bind acc_link_unit acc_link_checker #(.W(W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .mem_and    (mem_and),
  .mem_add    (mem_add),
  .mem_lda    (mem_lda),
  .io_inp     (io_inp),
  .rr_valid   (rr_valid),
  .rr_field   (rr_field),
  .dr_in      (dr_in),
  .char_in    (char_in),
  .acc_out    (acc_out),
  .link_out   (link_out),
  .run_out    (run_out),
  .skip_out   (skip_out)
);

// File: tb/acc_link_unit_test.sv
module acc_link_unit_test;
  localparam int K_NONE = 0, K_AND = 1, K_ADD = 2, K_LDA = 3, K_INP = 4, K_RR = 5;
  localparam logic [15:0] SV [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  logic        clk, rst_n;
  logic        mem_and, mem_add, mem_lda, io_inp, rr_valid;
  logic [11:0] rr_field;
  logic [15:0] dr_in;
  logic [7:0]  char_in;
  logic [15:0] acc_out;
  logic        link_out, run_out, skip_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_acc;
  logic        m_link, m_run;
  logic [15:0] x;

  acc_link_unit uut (
    .clk(clk), .rst_n(rst_n), .mem_and(mem_and), .mem_add(mem_add),
    .mem_lda(mem_lda), .io_inp(io_inp), .rr_valid(rr_valid), .rr_field(rr_field),
    .dr_in(dr_in), .char_in(char_in), .acc_out(acc_out), .link_out(link_out),
    .run_out(run_out), .skip_out(skip_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at the next falling edge with results checked
  task automatic op(input int kind, input logic [15:0] d, input logic [7:0] c,
                    input logic [11:0] f, input string req);
    logic [16:0] v;
    logic        exp_skip;
    mem_and  = (kind == K_AND);
    mem_add  = (kind == K_ADD);
    mem_lda  = (kind == K_LDA);
    io_inp   = (kind == K_INP);
    rr_valid = (kind == K_RR);
    rr_field = f;
    dr_in    = d;
    char_in  = c;
    exp_skip = (kind == K_RR) && ((f[4] && !m_acc[15]) || (f[3] && m_acc[15]) ||
                                  (f[2] && m_acc == 16'h0) || (f[1] && !m_link));
    #1;
    chk({req, " skip R10"}, {31'b0, skip_out}, {31'b0, exp_skip});
    case (kind)
      K_AND: m_acc = m_acc & d;
      K_ADD: begin v = {1'b0, m_acc} + {1'b0, d}; m_acc = v[15:0]; m_link = v[16]; end
      K_LDA: m_acc = d;
      K_INP: m_acc[7:0] = c;
      K_RR: begin
        if (f[11]) m_acc = 16'h0;
        if (f[10]) m_link = 1'b0;
        if (f[9])  m_acc = m_acc ^ 16'hFFFF;
        if (f[8])  m_link = !m_link;
        if (f[7]) begin v = {m_link, m_acc}; v = (v >> 1) | {v[0], 16'h0}; {m_link, m_acc} = v; end
        if (f[6]) begin v = {m_link, m_acc}; v = (v << 1) | {16'h0, v[16]}; {m_link, m_acc} = v; end
        if (f[5])  m_acc = 16'((32'(m_acc) + 1) % 65536);
        if (f[0])  m_run = 1'b0;
      end
      default: ;
    endcase
    @(negedge clk);
    mem_and = 0; mem_add = 0; mem_lda = 0; io_inp = 0; rr_valid = 0; rr_field = '0;
    chk({req, " acc"},  {16'b0, acc_out},  {16'b0, m_acc});
    chk({req, " link"}, {31'b0, link_out}, {31'b0, m_link});
    chk({req, " run"},  {31'b0, run_out},  {31'b0, m_run});
  endtask

  task automatic set_state(input logic [15:0] a, input logic l);
    op(K_LDA, a, 8'h00, 12'h000, "R4 setup");
    op(K_RR, 16'h0, 8'h00, l ? 12'h500 : 12'h400, "R9 setup");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_acc = 16'h0; m_link = 1'b0; m_run = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    mem_and = 0; mem_add = 0; mem_lda = 0; io_inp = 0; rr_valid = 0;
    rr_field = '0; dr_in = '0; char_in = '0;
    do_reset();
    // R1 reset state
    chk("R1 acc", {16'b0, acc_out}, 32'h0);
    chk("R1 link", {31'b0, link_out}, 32'h0);
    chk("R1 run", {31'b0, run_out}, 32'h1);
    chk("R1 skip", {31'b0, skip_out}, 32'h0);

    // R4 and R3 sweeps, including carry corners
    x = 16'h0001;
    op(K_LDA, 16'hFFFF, 8'h0, 12'h0, "R4");
    op(K_ADD, 16'h0001, 8'h0, 12'h0, "R3 wrap carry");
    op(K_LDA, 16'h8000, 8'h0, 12'h0, "R4");
    op(K_ADD, 16'h8000, 8'h0, 12'h0, "R3 msb carry");
    op(K_ADD, 16'h1234, 8'h0, 12'h0, "R3 no carry");
    for (int i = 0; i < 48; i++) begin
      op(K_LDA, x, 8'h0, 12'h0, "R4");
      x = nxt(x);
      op(K_ADD, x, 8'h0, 12'h0, "R3");
      x = nxt(x);
    end
    // R2 sweep, link set so it must survive
    set_state(16'hFFFF, 1'b1);
    for (int i = 0; i < 24; i++) begin
      op(K_AND, x, 8'h0, 12'h0, "R2");
      x = nxt(x);
      op(K_LDA, x | 16'h8421, 8'h0, 12'h0, "R4");
      x = nxt(x);
    end
    // R5 input byte
    set_state(16'hABCD, 1'b1);
    op(K_INP, 16'hFFFF, 8'h5A, 12'h0, "R5");
    op(K_INP, 16'h0000, 8'hFF, 12'h0, "R5");
    // R12 idle cycles with noisy data
    for (int i = 0; i < 4; i++) op(K_NONE, x ^ 16'hFFFF, 8'hA5, 12'hFFF, "R12 hold");

    // single register operations
    set_state(16'h1234, 1'b1);
    op(K_RR, 16'h0, 8'h0, 12'h800, "R6 clear acc");
    op(K_RR, 16'h0, 8'h0, 12'h400, "R6 clear link");
    op(K_RR, 16'h0, 8'h0, 12'h200, "R6 complement acc");
    op(K_RR, 16'h0, 8'h0, 12'h100, "R6 complement link");
    set_state(16'h8001, 1'b0);
    op(K_RR, 16'h0, 8'h0, 12'h080, "R7 rotate right");
    op(K_RR, 16'h0, 8'h0, 12'h080, "R7 rotate right");
    op(K_RR, 16'h0, 8'h0, 12'h040, "R7 rotate left");
    op(K_RR, 16'h0, 8'h0, 12'h040, "R7 rotate left");
    op(K_RR, 16'h0, 8'h0, 12'h040, "R7 rotate left");
    set_state(16'hFFFE, 1'b1);
    op(K_RR, 16'h0, 8'h0, 12'h020, "R8 increment");
    op(K_RR, 16'h0, 8'h0, 12'h020, "R8 wrap");
    op(K_RR, 16'h0, 8'h0, 12'h020, "R8 after wrap");

    // R9 every combination of the ordered bits
    for (int c = 0; c < 128; c++) begin
      set_state(x, x[3]);
      x = nxt(x);
      op(K_RR, 16'h0, 8'h0, {c[6:0], 5'b0}, "R9 combo");
    end

    // R10 skip tests over corner states and every skip selection
    for (int s = 0; s < 5; s++) begin
      for (int l = 0; l < 2; l++) begin
        for (int m = 0; m < 16; m++) begin
          set_state(SV[s], l[0]);
          op(K_RR, 16'h0, 8'h0, {7'b0, m[3:0], 1'b0}, "R10 skip");
        end
      end
    end
    set_state(16'hFFFF, 1'b0);
    op(K_RR, 16'h0, 8'h0, 12'h024, "R10 pre-update zero test");
    op(K_RR, 16'h0, 8'h0, 12'h024, "R10 pre-update zero test");

    // R11 halt is sticky until reset
    op(K_RR, 16'h0, 8'h0, 12'h001, "R11 halt");
    op(K_LDA, 16'h4321, 8'h0, 12'h0, "R11 stays cleared");
    op(K_RR, 16'h0, 8'h0, 12'h0A0, "R11 stays cleared");
    op(K_NONE, 16'h0, 8'h0, 12'h0, "R11 stays cleared");
    // R1 reset again
    rst_n = 1'b0;
    #1;
    chk("R1 async acc", {16'b0, acc_out}, 32'h0);
    chk("R1 async run", {31'b0, run_out}, 32'h1);
    do_reset();
    chk("R1 re-reset link", {31'b0, link_out}, 32'h0);
    chk("R1 re-reset run", {31'b0, run_out}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule